// File: doc/BRIEF.md
# Sequential Add-Shift Multiplier

This block multiplies two unsigned operands of `N` bits (4 by default) into a product of `2N` bits. It has one adder of `N` bits and a double-width working register. The low half of that register is loaded with the multiplier and the upper half is cleared. The block then runs `2N` single-cycle steps, which alternate between add and shift. On an add step, the multiplicand is added into the upper half only when the lowest bit of the working register is 1. On a shift step, the carry and the working register move right by one position, which retires one multiplier bit.

A caller pulses `start` with the operands on `a` and `b`. A `done` pulse one cycle wide marks the moment the product appears on `q`. The value on `q` stays unchanged until the next multiplication finishes. A request that arrives while a multiplication is running is dropped.

Top module: `addshift_mul`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `q` is 0 and `done` is 0.
- R2: When the block finishes, `q` equals the unsigned product a*b of the operands that were sampled with the accepted `start`. Two examples: 13*5 gives 65 (8'b01000001) and 10*3 gives 30 (8'b00011110).
- R3: `done` is high in the cycle that follows the 2N-th rising edge after the edge that accepted `start`. For N=4 this is 8 edges.
- R4: `done` stays high for exactly one cycle for each multiplication.
- R5: `q` changes only on the edge that raises `done`. During a later multiplication it keeps the previous product.
- R6: A `start` that is high while a multiplication is running has no effect. The running product and its completion cycle stay unchanged.
- R7: An add step leaves the working register unchanged when the current multiplier bit is 0. A zero operand therefore gives a product of 0. All-ones operands give 15*15 = 225 with no lost carry.
- R8: A shift step moves the working register right by one bit and puts the add carry into the top bit.
- R9: A `start` in the same cycle that `done` is high is accepted and begins a new multiplication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication; accepted only when idle |
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned |
| q | output | 2N | Product, held until the next completion |
| done | output | 1 | One-cycle pulse when `q` is updated |

## Verification
A table of operand pairs covers these cases:
- The two worked examples.
- Zero in either operand. This separates a correct skipped add from an add that always happens.
- All ones. This exposes a dropped carry out of the adder.
- Single-bit multipliers. These show whether every shift lines up with its add.

After the table, all 256 operand pairs are swept, and each one checks both the product and the exact completion cycle. Directed sequences then cover these cases:
- A second `start` arriving in the middle of a run, which must be ignored.
- A restart on the cycle that `done` is high.
- The hold of the old product during a new run.

// File: rtl/addshift_mul.sv
module addshift_mul #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] q,
  output logic           done
);

  localparam int W  = 2 * N;
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy;
  logic [CW-1:0] step;
  logic [N-1:0]  mcand;
  logic [W-1:0]  acc;
  logic          carry;
  logic [N:0]    sum;

  wire shift_ph = step[0];
  wire last_ph  = (step == LAST);

  assign sum = {1'b0, acc[W-1:N]} + {1'b0, mcand};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      step  <= '0;
      mcand <= '0;
      acc   <= '0;
      carry <= 1'b0;
      q     <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          mcand <= a;
          acc   <= {{N{1'b0}}, b};
          carry <= 1'b0;
          step  <= '0;
          busy  <= 1'b1;
        end
      end else begin
        if (!shift_ph) begin
          if (acc[0]) {carry, acc[W-1:N]} <= sum;
        end else begin
          acc   <= {carry, acc[W-1:1]};
          carry <= 1'b0;
        end
        if (last_ph) begin
          busy <= 1'b0;
          done <= 1'b1;
          q    <= {carry, acc[W-1:1]};
        end
        step <= step + 1'b1;
      end
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  p_q_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(q));

  p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_ph |=> busy && $stable(mcand));

  p_skip_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !shift_ph && !acc[0] |=> $stable(acc) && !carry);

  p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && shift_ph |=> acc[W-2:0] == $past(acc[W-1:1]) && !carry);

  p_first_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> step == '0);

endmodule

// File: tb/addshift_mul_tb.sv
module addshift_mul_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int NV = 10;
  localparam logic [7:0] VEC [NV] = '{
    {4'd13, 4'd5}, {4'd10, 4'd3}, {4'd0, 4'd15}, {4'd15, 4'd0},
    {4'd15, 4'd15}, {4'd1, 4'd1}, {4'd9, 4'd8}, {4'd7, 4'd1},
    {4'd15, 4'd4}, {4'd6, 4'd9}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [N-1:0] a = '0, b = '0;
  logic [2*N-1:0] q;
  logic done;
  int checks = 0, fails = 0;

  addshift_mul #(.N(N)) dut_i (.clk, .rst_n, .start, .a, .b, .q, .done);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // drive start at a negedge; returns after the accepting edge, at the next negedge
  task automatic kick(input logic [N-1:0] x, input logic [N-1:0] y);
    a = x; b = y; start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 40) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
  endtask

  task automatic mul(input logic [N-1:0] x, input logic [N-1:0] y, input string req);
    int cyc;
    kick(x, y);
    wait_done(cyc);
    chk(req, q == 8'(x * y), int'(q), int'(x) * int'(y));
    chk("R3", cyc == 2 * N, cyc, 2 * N);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk("watchdog", 1'b0, 0, 1);
    finish_run();
  end

  initial begin
    int cyc;
    @(negedge clk);
    chk("R1", q == 0 && done == 0, int'(q), 0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); @(negedge clk);
    chk("R1", q == 0 && done == 0, int'(done), 0);

    for (int i = 0; i < NV; i++) mul(VEC[i][7:4], VEC[i][3:0], "R2/R7");

    // R4: done lasts exactly one cycle
    kick(4'd12, 4'd11);
    wait_done(cyc);
    chk("R2", q == 8'd132, int'(q), 132);
    @(posedge clk); @(negedge clk);
    chk("R4", done == 0, int'(done), 0);

    // R5: old product held during the next run
    kick(4'd3, 4'd3);
    repeat (5) begin @(posedge clk); @(negedge clk); end
    chk("R5", q == 8'd132 && !done, int'(q), 132);
    wait_done(cyc);
    chk("R5", q == 8'd9, int'(q), 9);

    // R6: start while busy is ignored
    kick(4'd13, 4'd5);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    a = 4'd2; b = 4'd2; start = 1;
    @(posedge clk); @(negedge clk);
    start = 0;
    wait_done(cyc);
    chk("R6", q == 8'd65, int'(q), 65);
    chk("R6", cyc == 2 * N - 4, cyc + 4, 2 * N);
    @(posedge clk); @(negedge clk);
    chk("R6", !done && q == 8'd65, int'(q), 65);

    // R9: restart in the done cycle
    kick(4'd10, 4'd3);
    wait_done(cyc);
    chk("R2", q == 8'd30, int'(q), 30);
    kick(4'd11, 4'd7);
    wait_done(cyc);
    chk("R9", q == 8'd77 && cyc == 2 * N, int'(q), 77);

    // R7/R8: exhaustive sweep
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) mul(4'(x), 4'(y), "R2/R8");

    finish_run();
  end
endmodule